// File: doc/BRIEF.md
# Software Watchdog Timer with Bus-Lock Escape

This block watches for a periodic servicing sequence from software. While the watchdog is switched on, a free-running count rises toward a programmable limit. Software restarts the count by writing a two-byte key pair to a service register. If the pair stops arriving, the count reaches its limit. The block then either raises an interrupt request or pulls the system reset output low for a fixed time. A control bit picks which of the two happens.

The watchdog interrupt has no automatic vector, so the block watches an interrupt-acknowledge input that marks the matching acknowledge cycle. The interrupt can stay pending because the processor is stuck in a bus cycle that never ends. In that case a further expiry can make the block emit a one-cycle transfer-acknowledge pulse to close the stuck cycle, and a sticky status bit records the event. A read-only reset-cause register shows whether the last reset came from the external reset pin or from the watchdog.

The control sequence is a four-state machine:
- ST_IDLE: switched off.
- ST_COUNT: counting toward the limit.
- ST_IRQ: interrupt pending, still counting.
- ST_HOLD: driving the reset output.

The transitions are:
- ST_IDLE to ST_COUNT: a control write with the enable bit set.
- ST_COUNT or ST_IRQ to ST_IDLE: a control write with the enable bit clear.
- ST_COUNT to ST_IRQ: an expiry in interrupt mode.
- ST_COUNT to ST_HOLD: an expiry in reset mode.
- ST_IRQ to ST_COUNT: an acknowledge cycle.
- ST_IRQ to ST_IRQ: a further expiry, which may emit the escape pulse.
- ST_HOLD to ST_IDLE: after 16 clocks.

Top module: `wdog_lockbreak`

## Requirements
- R1: While control bit 0 (enable) is 0, the block never expires: `irq` and `ta_pulse` stay low and `sys_rst_n` stays high. Writing 0 to the enable bit while an interrupt is pending drops `irq` on the next cycle.
- R2: The timeout is 2^(10+S) clocks, where S is control bits 6:4. Any S of 6 or more gives 2^16. `irq` rises exactly that many clock edges after the control write that started the count.
- R3: Writing 0x55 and then 0xAA to the service register (address 1) restarts the count at the 0xAA write. Any other byte clears the sequence tracker. A 0xAA with no 0x55 before it does not restart the count.
- R4: With control bit 1 (action) at 0, an expiry raises `irq`, and it stays high until it is acknowledged or the watchdog is switched off.
- R5: With control bit 1 at 1, an expiry drives `sys_rst_n` low for exactly 16 clocks and clears the control register to 0, which switches the watchdog off.
- R6: A pulse on `iack` while `irq` is high drops `irq` on the next cycle and restarts the count. A pulse on `iack` with no interrupt pending has no effect on timing.
- R7: With control bit 2 (escape enable) at 1 and `irq` high, each further expiry without an acknowledge gives a one-cycle high pulse on `ta_pulse`, and `irq` stays high. With bit 2 at 0, no pulse occurs.
- R8: Status register bit 0 (address 2) is set by every `ta_pulse`. It is cleared only by writing 1 to that bit; writing 0 leaves it set.
- R9: The reset-cause register (address 3) reads 0x80 after an external reset (bit 7 set). It reads 0x20 (bit 5 set) from the first cycle of a watchdog reset onward. All other bits read 0.
- R10: Reading address 0 returns the control fields in place (bits 0, 1, 2 and 6:4), with bits 3 and 7 reading 0. Writing the control register does not change the state while the enable bit is clear.
- R11: Writing the control register while counting restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 service, 2 status, 3 reset cause |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| iack | input | 1 | Acknowledge cycle seen for the watchdog interrupt |
| irq | output | 1 | Watchdog interrupt request |
| ta_pulse | output | 1 | One-cycle transfer-acknowledge pulse that ends a stuck bus cycle |
| sys_rst_n | output | 1 | System reset output, active low |

## Verification
The expiry is driven by several patterns, each aimed at telling apart the cases that matter.
- **Start instant:** plain enabling with no service, checked one cycle before and at the predicted edge, pins down the exact start instant and period.
- **Restart sources:** a correct key pair, a corrupted key pair, a stray acknowledge, a real acknowledge and a control rewrite each either move the expiry or leave it in place. Checking on both sides of the expected edge shows which inputs actually restart the count.
- **Stuck interrupt:** letting an interrupt sit through a second expiry, with the escape bit on and then off, separates the bus-escape path from the plain pending interrupt.
- **Reset mode:** reset mode is checked against the exact hold length and against the cause register before and after an external reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_IRQ   = 2'd2,
        ST_HOLD  = 2'd3
    } wdog_state_t;

    localparam logic [1:0] ADR_CTRL  = 2'd0;
    localparam logic [1:0] ADR_SVC   = 2'd1;
    localparam logic [1:0] ADR_STAT  = 2'd2;
    localparam logic [1:0] ADR_CAUSE = 2'd3;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
    import wdog_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              svc_wr,
    input  logic [DATA_W-1:0] svc_data,
    output logic              svc_ok
);

    logic armed;

    assign svc_ok = svc_wr && (svc_data == DATA_W'(KEY_SECOND)) && armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (svc_wr) begin
            armed <= (svc_data == DATA_W'(KEY_FIRST));
        end
    end

    // R3: a completed pair consumes the arming
    a_r3_pair_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> !armed);
    // R3: any byte other than the first key leaves the tracker unarmed
    a_r3_stray_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && svc_data != DATA_W'(KEY_FIRST)) |=> !armed);

endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
    parameter int MIN_EXP = 10,
    parameter int MAX_SEL = 6,
    parameter int SEL_W   = 3,
    localparam int CNT_W  = MIN_EXP + MAX_SEL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic [SEL_W-1:0] sel_eff;
    logic [SEL_W-1:0] shift;

    always_comb begin
        sel_eff = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;
        shift   = SEL_W'(MAX_SEL) - sel_eff;
        lim     = {CNT_W{1'b1}} >> shift;
        expire  = run && !restart && (cnt == lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !run || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: the count never passes the selected limit
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim);
    // R2: an expiry always starts the next period from zero
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt == '0));

endmodule

// File: rtl/wdog_lockbreak.sv
module wdog_lockbreak
    import wdog_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MIN_EXP  = 10,
    parameter int MAX_SEL  = 6,
    parameter int SEL_W    = 3,
    parameter int HOLD_CYC = 16,
    localparam int HOLD_W  = $clog2(HOLD_CYC)
) (
    input  logic              clk,
    input  logic              ext_rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              iack,
    output logic              irq,
    output logic              ta_pulse,
    output logic              sys_rst_n
);

    wdog_state_t state, nxt;

    logic             en_q, act_rst_q, esc_en_q;
    logic [SEL_W-1:0] sel_q;
    logic             esc_flag;
    logic             cause_ext, cause_wd;
    logic [HOLD_W-1:0] hold_cnt;
    logic             ta_q;

    logic ctrl_wr, svc_wr, stat_wr;
    logic svc_ok, iack_take, restart, run, expire, enter_hold, esc_fire;

    assign ctrl_wr    = wr_en && (addr == ADR_CTRL) && (state != ST_HOLD);
    assign svc_wr     = wr_en && (addr == ADR_SVC)  && (state != ST_HOLD);
    assign stat_wr    = wr_en && (addr == ADR_STAT);
    assign iack_take  = iack && (state == ST_IRQ);
    assign restart    = ctrl_wr || svc_ok || iack_take;
    assign run        = (state == ST_COUNT) || (state == ST_IRQ);
    assign enter_hold = (state == ST_COUNT) && expire && act_rst_q;
    assign esc_fire   = (state == ST_IRQ) && expire && esc_en_q;

    wdog_key_seq #(.DATA_W(DATA_W)) u_keys (
        .clk      (clk),
        .rst_n    (ext_rst_n),
        .svc_wr   (svc_wr),
        .svc_data (wr_data),
        .svc_ok   (svc_ok)
    );

    wdog_timebase #(.MIN_EXP(MIN_EXP), .MAX_SEL(MAX_SEL), .SEL_W(SEL_W)) u_tbase (
        .clk     (clk),
        .rst_n   (ext_rst_n),
        .run     (run),
        .restart (restart),
        .sel     (sel_q),
        .expire  (expire)
    );

    // State register
    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (ctrl_wr && wr_data[0]) nxt = ST_COUNT;
            end
            ST_COUNT: begin
                if (ctrl_wr && !wr_data[0]) nxt = ST_IDLE;
                else if (expire)            nxt = act_rst_q ? ST_HOLD : ST_IRQ;
            end
            ST_IRQ: begin
                if (ctrl_wr && !wr_data[0]) nxt = ST_IDLE;
                else if (iack)              nxt = ST_COUNT;
            end
            ST_HOLD: begin
                if (hold_cnt == HOLD_W'(HOLD_CYC - 1)) nxt = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        irq       = (state == ST_IRQ);
        sys_rst_n = (state != ST_HOLD);
        ta_pulse  = ta_q;
        unique case (addr)
            ADR_CTRL:  rd_data = DATA_W'({1'b0, sel_q, 1'b0, esc_en_q, act_rst_q, en_q});
            ADR_SVC:   rd_data = '0;
            ADR_STAT:  rd_data = DATA_W'(esc_flag);
            ADR_CAUSE: rd_data = DATA_W'({cause_ext, 1'b0, cause_wd, 5'b0});
        endcase
    end

    // Control, status and cause registers
    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            en_q      <= 1'b0;
            act_rst_q <= 1'b0;
            esc_en_q  <= 1'b0;
            sel_q     <= '0;
            esc_flag  <= 1'b0;
            cause_ext <= 1'b1;
            cause_wd  <= 1'b0;
            hold_cnt  <= '0;
            ta_q      <= 1'b0;
        end else begin
            ta_q <= esc_fire;
            if (enter_hold) begin
                en_q      <= 1'b0;
                act_rst_q <= 1'b0;
                esc_en_q  <= 1'b0;
                sel_q     <= '0;
                cause_ext <= 1'b0;
                cause_wd  <= 1'b1;
            end else if (ctrl_wr) begin
                en_q      <= wr_data[0];
                act_rst_q <= wr_data[1];
                esc_en_q  <= wr_data[2];
                sel_q     <= wr_data[4 +: SEL_W];
            end
            if (esc_fire) begin
                esc_flag <= 1'b1;
            end else if (stat_wr && wr_data[0]) begin
                esc_flag <= 1'b0;
            end
            hold_cnt <= (state == ST_HOLD) ? hold_cnt + 1'b1 : '0;
        end
    end

    // R7: the escape pulse lasts one cycle
    a_r7_ta_single: assert property (@(posedge clk) disable iff (!ext_rst_n)
        ta_pulse |=> !ta_pulse);
    // R7: the escape pulse only appears with an interrupt still pending
    a_r7_ta_with_irq: assert property (@(posedge clk) disable iff (!ext_rst_n)
        ta_pulse |-> irq);
    // R8: every escape pulse is recorded in the sticky flag
    a_r8_flag_tracks: assert property (@(posedge clk) disable iff (!ext_rst_n)
        ta_pulse |-> esc_flag);
    // R9: while reset is driven, the cause register shows the watchdog
    a_r9_hold_cause: assert property (@(posedge clk) disable iff (!ext_rst_n)
        !sys_rst_n |-> (cause_wd && !cause_ext));
    // R1: with the enable bit clear, no interrupt is raised
    a_r1_off_quiet: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (!en_q && sys_rst_n) |-> !irq);
    // R6: an acknowledge clears a pending interrupt
    a_r6_iack_drop: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (irq && iack) |=> !irq);

endmodule

// File: tb/wdog_lockbreak_bench.sv
module wdog_lockbreak_bench;

    localparam int L0 = 1024;
    localparam int L1 = 2048;

    logic       clk = 1'b0;
    logic       ext_rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       iack = 1'b0;
    logic       irq, ta_pulse, sys_rst_n;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    wdog_lockbreak u_wdog_lockbreak (
        .clk       (clk),
        .ext_rst_n (ext_rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .iack      (iack),
        .irq       (irq),
        .ta_pulse  (ta_pulse),
        .sys_rst_n (sys_rst_n)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
        addr = 2'd0;
    endtask

    task automatic pulse_iack();
        iack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        iack = 1'b0;
    endtask

    task automatic do_ext_reset();
        ext_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        ext_rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_ext_reset();
        chk("R1 irq after reset", 16'(irq), 16'd0);
        chk("R1 ta after reset", 16'(ta_pulse), 16'd0);
        chk("R1 sys_rst_n after reset", 16'(sys_rst_n), 16'd1);
        rd(2'd3, v); chk("R9 cause after external reset", 16'(v), 16'h80);
        rd(2'd0, v); chk("R10 control after reset", 16'(v), 16'h00);
        rd(2'd2, v); chk("R8 flag after reset", 16'(v), 16'h00);
    endtask

    task automatic t_disabled();
        int hits = 0;
        wr(2'd0, 8'h06);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (irq || ta_pulse || !sys_rst_n) hits++;
        end
        chk("R1 disabled never expires", 16'(hits), 16'd0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_readback();
        logic [7:0] v;
        wr(2'd0, 8'hFE);
        rd(2'd0, v); chk("R10 control readback", 16'(v), 16'h76);
        wait_n(5);
        chk("R10 no activity with enable clear", 16'(irq), 16'd0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_irq_timing();
        wr(2'd0, 8'h01);
        wait_n(300);
        pulse_iack();
        wait_n(L0 - 1 - 301);
        chk("R6 stray iack ignored, R2 not yet", 16'(irq), 16'd0);
        wait_n(1);
        chk("R2 R4 irq at 2^10", 16'(irq), 16'd1);
        wait_n(50);
        chk("R4 irq held", 16'(irq), 16'd1);
        pulse_iack();
        chk("R6 iack drops irq", 16'(irq), 16'd0);
        wait_n(L0 - 1);
        chk("R6 restart after iack, before", 16'(irq), 16'd0);
        wait_n(1);
        chk("R6 restart after iack, at", 16'(irq), 16'd1);
        pulse_iack();
        wait_n(500);
        wr(2'd0, 8'h01);
        wait_n(L0 - 1);
        chk("R11 control write restarts, before", 16'(irq), 16'd0);
        wait_n(1);
        chk("R11 control write restarts, at", 16'(irq), 16'd1);
        wr(2'd0, 8'h00);
        chk("R1 disable drops irq", 16'(irq), 16'd0);
    endtask

    task automatic t_service();
        wr(2'd0, 8'h01);
        wait_n(400);
        wr(2'd1, 8'h55);
        wr(2'd1, 8'hAA);
        wait_n(L0 - 1);
        chk("R3 good pair restarts, before", 16'(irq), 16'd0);
        wait_n(1);
        chk("R3 good pair restarts, at", 16'(irq), 16'd1);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_bad_service();
        wr(2'd0, 8'h01);
        wait_n(100);
        wr(2'd1, 8'h55);
        wr(2'd1, 8'h12);
        wr(2'd1, 8'hAA);
        wait_n(L0 - 1 - 103);
        chk("R3 broken pair no restart, before", 16'(irq), 16'd0);
        wait_n(1);
        chk("R3 broken pair no restart, at", 16'(irq), 16'd1);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_escape();
        logic [7:0] v;
        wr(2'd0, 8'h05);
        wait_n(L0);
        chk("R4 irq before escape", 16'(irq), 16'd1);
        wait_n(L0 - 1);
        chk("R7 no pulse before second expiry", 16'(ta_pulse), 16'd0);
        wait_n(1);
        chk("R7 pulse at second expiry", 16'(ta_pulse), 16'd1);
        chk("R7 irq kept with pulse", 16'(irq), 16'd1);
        wait_n(1);
        chk("R7 pulse one cycle", 16'(ta_pulse), 16'd0);
        rd(2'd2, v); chk("R8 flag set", 16'(v), 16'h01);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R8 write 0 keeps flag", 16'(v), 16'h01);
        wr(2'd2, 8'h01);
        rd(2'd2, v); chk("R8 write 1 clears flag", 16'(v), 16'h00);
        pulse_iack();
        chk("R6 iack after escape", 16'(irq), 16'd0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_escape_off();
        logic [7:0] v;
        int pulses = 0;
        wr(2'd0, 8'h01);
        for (int i = 0; i < 2 * L0 + 5; i++) begin
            @(negedge clk);
            if (ta_pulse) pulses++;
        end
        chk("R7 no pulse with escape off", 16'(pulses), 16'd0);
        rd(2'd2, v); chk("R8 flag stays clear", 16'(v), 16'h00);
        pulse_iack();
        wr(2'd0, 8'h00);
    endtask

    task automatic t_sel();
        wr(2'd0, 8'h11);
        wait_n(L1 - 1);
        chk("R2 sel 1 before 2^11", 16'(irq), 16'd0);
        wait_n(1);
        chk("R2 sel 1 at 2^11", 16'(irq), 16'd1);
        pulse_iack();
        wr(2'd0, 8'h00);
    endtask

    task automatic t_wd_reset();
        logic [7:0] v;
        int lows = 0;
        logic last = 1'b0;
        wr(2'd0, 8'h03);
        wait_n(L0 - 1);
        chk("R5 reset not yet", 16'(sys_rst_n), 16'd1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!sys_rst_n) lows++;
            if (i == 0) begin
                rd(2'd3, v); chk("R9 cause during hold", 16'(v), 16'h20);
            end
            last = sys_rst_n;
        end
        chk("R5 reset length 16", 16'(lows), 16'd16);
        chk("R5 reset released", 16'(last), 16'd1);
        chk("R5 no irq in reset mode", 16'(irq), 16'd0);
        rd(2'd0, v); chk("R5 control cleared", 16'(v), 16'h00);
        rd(2'd3, v); chk("R9 cause after hold", 16'(v), 16'h20);
        do_ext_reset();
        rd(2'd3, v); chk("R9 cause after new external reset", 16'(v), 16'h80);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_disabled();
        t_readback();
        t_irq_timing();
        t_service();
        t_bad_service();
        t_escape();
        t_escape_off();
        t_sel();
        t_wd_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule